// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block sequences the operating modes of an 8-bit processor. It takes a decoded halt instruction strobe and a decoded sleep instruction strobe, along with three power-control bits, and moves the processor between Normal, HALT and SLEEP. It gates the clock enables for the CPU core, the DMA engine and DRAM refresh, and it drives the active-low HALT, status (ST) and M1 pins. During SLEEP it forces the address and bus control lines high.

Wake requests come from NMI, three external interrupt lines, an on-chip interrupt source and reset. Each of these is registered before the sequencer uses it. HALT wakes only on an interrupt whose enable bit is set. SLEEP wakes on any request, whether its enable is set or not. When the block leaves a low-power mode it asserts a one-cycle wake pulse. Alongside the pulse it presents the resume address, which is the address of the entering opcode plus one.

The remaining mode combinations are decoded into a mode code. They behave like SLEEP and carry no other function: I/O stop, system stop, idle, standby and quick-recovery standby.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_ni is low and just after it rises, the outputs take their reset values: mode_o=0 (Normal), halt_no=1, cpu_clk_en_o=dma_clk_en_o=refresh_en_o=1, bus_force_hi_o=0, exec_inhibit_o=0 and wake_o=0.
- R2: In Normal, st_no and m1_no follow core_st_ni and core_m1_ni, halt_no is 1, all three clock enables are 1 and exec_inhibit_o is 0. If iostop_i=1 in Normal, mode_o reads 2; otherwise it reads 0.
- R3: A halt_op_i pulse in Normal puts the block in HALT (mode_o=1) from the next cycle. halt_op_i takes priority over slp_op_i.
- R4: In HALT, halt_no, st_no and m1_no are 0 and exec_inhibit_o is 1. All three clock enables stay 1 and bus_force_hi_o is 0.
- R5: HALT is left on a registered NMI, or on a registered request from INTn or the on-chip source whose enable is also set. A request whose enable is clear leaves the block in HALT.
- R6: On leaving any low-power mode, wake_o is 1 for exactly one cycle, the cycle before mode_o returns to Normal. resume_addr_o equals op_addr_i at entry plus one, modulo 2^ADDR_W.
- R7: An slp_op_i pulse in Normal with iostop_i, ccr3_i and ccr6_i all 0 enters SLEEP (mode_o=3).
- R8: In SLEEP, all three clock enables are 0, halt_no is 0, st_no and m1_no are 1, and exec_inhibit_o is 1. bus_force_hi_o is 1 unless bus_grant_i is 1, in which case it is 0.
- R9: SLEEP and the other sleep-class modes are left on any registered NMI, INTn or on-chip request, whatever its enable bit.
- R10: An slp_op_i pulse with control bits set selects a mode as follows. ccr6_i=1 gives 6, or 7 if ccr3_i=1 as well. Otherwise ccr3_i=1 gives 5. Otherwise iostop_i=1 gives 4.
- R11: Wake sources are sampled through one register. A request present in the entry cycle makes wake_o=1 in the first low-power cycle, and the block is back in Normal one cycle later.
- R12: Pulling rst_ni low in any mode returns the block to Normal at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_op_i | input | 1 | Decoded halt instruction strobe |
| slp_op_i | input | 1 | Decoded sleep instruction strobe |
| op_addr_i | input | ADDR_W | Address of the entering opcode |
| iostop_i | input | 1 | I/O stop control bit |
| ccr3_i | input | 1 | Power control bit 3 |
| ccr6_i | input | 1 | Power control bit 6 |
| nmi_i | input | 1 | Non-maskable interrupt request |
| int_req_i | input | N_INT | External interrupt requests |
| int_en_i | input | N_INT | External interrupt enables |
| onchip_irq_i | input | 1 | On-chip interrupt request |
| onchip_en_i | input | 1 | On-chip interrupt enable |
| bus_grant_i | input | 1 | Bus granted to an external master |
| core_st_ni | input | 1 | Core status strobe, active low |
| core_m1_ni | input | 1 | Core M1 strobe, active low |
| mode_o | output | 3 | Current mode code |
| halt_no | output | 1 | HALT pin, active low |
| st_no | output | 1 | ST pin, active low |
| m1_no | output | 1 | M1 pin, active low |
| bus_force_hi_o | output | 1 | Forces the address and control lines high |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| dma_clk_en_o | output | 1 | DMA clock enable |
| refresh_en_o | output | 1 | DRAM refresh enable |
| exec_inhibit_o | output | 1 | Fetch continues, execution is suppressed |
| wake_o | output | 1 | One-cycle wake pulse |
| resume_addr_o | output | ADDR_W | Address at which execution resumes |

## Verification
The hardest case is a wake request that arrives in the same cycle as the entry strobe, because the registered sample has to produce a wake in the very first low-power cycle. The bench raises NMI on the same falling edge that raises halt_op_i. It then checks that wake_o rises one cycle later and that mode_o is Normal in the cycle after that. A masked request in HALT is kept on for several cycles before its enable is set. This shows the difference between HALT and SLEEP wake behaviour at the ports.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_HALT    = 3'd1,
    M_IOSTOP  = 3'd2,
    M_SLEEP   = 3'd3,
    M_SYSSTOP = 3'd4,
    M_IDLE    = 3'd5,
    M_STBY    = 3'd6,
    M_STBY_QR = 3'd7
  } mode_e;

  function automatic logic is_sleep_class(mode_e m);
    return (m == M_SLEEP) || (m == M_SYSSTOP) || (m == M_IDLE) ||
           (m == M_STBY) || (m == M_STBY_QR);
  endfunction
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int N_INT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic             onchip_irq_i,
  input  logic             onchip_en_i,
  output logic             wake_masked_o,
  output logic             wake_any_o
);
  logic             nmi_q, onchip_q, onchip_en_q;
  logic [N_INT-1:0] req_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q       <= 1'b0;
      onchip_q    <= 1'b0;
      onchip_en_q <= 1'b0;
    end else begin
      nmi_q       <= nmi_i;
      onchip_q    <= onchip_irq_i;
      onchip_en_q <= onchip_en_i;
    end
  end

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[g] <= 1'b0;
        en_q[g]  <= 1'b0;
      end else begin
        req_q[g] <= int_req_i[g];
        en_q[g]  <= int_en_i[g];
      end
    end
  end

  assign wake_masked_o = nmi_q | (|(req_q & en_q)) | (onchip_q & onchip_en_q);
  assign wake_any_o    = nmi_q | (|req_q) | onchip_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_op_i,
  input  logic              slp_op_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              iostop_i,
  input  logic              ccr3_i,
  input  logic              ccr6_i,
  input  logic              wake_masked_i,
  input  logic              wake_any_i,
  output mode_e             state_o,
  output logic              wake_o,
  output logic [ADDR_W-1:0] resume_addr_o
);
  mode_e             state_q, state_d;
  logic [ADDR_W-1:0] resume_q;
  logic              entering;

  function automatic mode_e slp_target(logic io, logic c3, logic c6);
    if (c6)      return c3 ? M_STBY_QR : M_STBY;
    else if (c3) return M_IDLE;
    else if (io) return M_SYSSTOP;
    else         return M_SLEEP;
  endfunction

  always_comb begin
    wake_o = 1'b0;
    if (state_q == M_HALT)          wake_o = wake_masked_i;
    else if (is_sleep_class(state_q)) wake_o = wake_any_i;
  end

  always_comb begin
    state_d  = state_q;
    entering = 1'b0;
    if (state_q == M_NORMAL) begin
      if (halt_op_i) begin
        state_d  = M_HALT;
        entering = 1'b1;
      end else if (slp_op_i) begin
        state_d  = slp_target(iostop_i, ccr3_i, ccr6_i);
        entering = 1'b1;
      end
    end else if (wake_o) begin
      state_d = M_NORMAL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= M_NORMAL;
      resume_q <= '0;
    end else begin
      state_q <= state_d;
      if (entering) resume_q <= op_addr_i + ADDR_W'(1);
    end
  end

  assign state_o       = state_q;
  assign resume_addr_o = resume_q;
endmodule

// File: rtl/lpm_pin_drive.sv
module lpm_pin_drive
  import lpm_pkg::*;
(
  input  mode_e      state_i,
  input  logic       iostop_i,
  input  logic       bus_grant_i,
  input  logic       core_st_ni,
  input  logic       core_m1_ni,
  output logic [2:0] mode_o,
  output logic       halt_no,
  output logic       st_no,
  output logic       m1_no,
  output logic       bus_force_hi_o,
  output logic       cpu_clk_en_o,
  output logic       dma_clk_en_o,
  output logic       refresh_en_o,
  output logic       exec_inhibit_o
);
  always_comb begin
    mode_o         = state_i;
    halt_no        = 1'b1;
    st_no          = core_st_ni;
    m1_no          = core_m1_ni;
    bus_force_hi_o = 1'b0;
    cpu_clk_en_o   = 1'b1;
    dma_clk_en_o   = 1'b1;
    refresh_en_o   = 1'b1;
    exec_inhibit_o = 1'b0;
    if (state_i == M_NORMAL) begin
      if (iostop_i) mode_o = M_IOSTOP;
    end else if (state_i == M_HALT) begin
      halt_no        = 1'b0;
      st_no          = 1'b0;
      m1_no          = 1'b0;
      exec_inhibit_o = 1'b1;
    end else begin
      halt_no        = 1'b0;
      st_no          = 1'b1;
      m1_no          = 1'b1;
      bus_force_hi_o = ~bus_grant_i;
      cpu_clk_en_o   = 1'b0;
      dma_clk_en_o   = 1'b0;
      refresh_en_o   = 1'b0;
      exec_inhibit_o = 1'b1;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int N_INT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_op_i,
  input  logic              slp_op_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              iostop_i,
  input  logic              ccr3_i,
  input  logic              ccr6_i,
  input  logic              nmi_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic [N_INT-1:0]  int_en_i,
  input  logic              onchip_irq_i,
  input  logic              onchip_en_i,
  input  logic              bus_grant_i,
  input  logic              core_st_ni,
  input  logic              core_m1_ni,
  output logic [2:0]        mode_o,
  output logic              halt_no,
  output logic              st_no,
  output logic              m1_no,
  output logic              bus_force_hi_o,
  output logic              cpu_clk_en_o,
  output logic              dma_clk_en_o,
  output logic              refresh_en_o,
  output logic              exec_inhibit_o,
  output logic              wake_o,
  output logic [ADDR_W-1:0] resume_addr_o
);
  logic  wake_masked, wake_any;
  mode_e state;

  lpm_wake_sync #(.N_INT(N_INT)) u_wake (
    .clk_i, .rst_ni, .nmi_i, .int_req_i, .int_en_i, .onchip_irq_i, .onchip_en_i,
    .wake_masked_o(wake_masked), .wake_any_o(wake_any)
  );

  lpm_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .halt_op_i, .slp_op_i, .op_addr_i, .iostop_i, .ccr3_i, .ccr6_i,
    .wake_masked_i(wake_masked), .wake_any_i(wake_any),
    .state_o(state), .wake_o, .resume_addr_o
  );

  lpm_pin_drive u_pins (
    .state_i(state), .iostop_i, .bus_grant_i, .core_st_ni, .core_m1_ni,
    .mode_o, .halt_no, .st_no, .m1_no, .bus_force_hi_o, .cpu_clk_en_o,
    .dma_clk_en_o, .refresh_en_o, .exec_inhibit_o
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_op_i,
  input logic       nmi_i,
  input logic       bus_grant_i,
  input logic [2:0] mode_o,
  input logic       halt_no,
  input logic       st_no,
  input logic       m1_no,
  input logic       bus_force_hi_o,
  input logic       cpu_clk_en_o,
  input logic       dma_clk_en_o,
  input logic       refresh_en_o,
  input logic       wake_o
);
  logic low_pwr;
  assign low_pwr = (mode_o != 3'd0) && (mode_o != 3'd2);

  p_halt_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!low_pwr && halt_op_i) |=> (mode_o == 3'd1));

  p_halt_pins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> (!halt_no && !st_no && !m1_no && cpu_clk_en_o && dma_clk_en_o && refresh_en_o));

  p_wake_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !low_pwr);

  p_sleep_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (!cpu_clk_en_o && !dma_clk_en_o && !refresh_en_o && !halt_no));

  p_sleep_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && !bus_grant_i) |-> bus_force_hi_o);

  p_nmi_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pwr && $past(nmi_i)) |-> wake_o);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_op_i(halt_op_i), .nmi_i(nmi_i),
  .bus_grant_i(bus_grant_i), .mode_o(mode_o), .halt_no(halt_no), .st_no(st_no),
  .m1_no(m1_no), .bus_force_hi_o(bus_force_hi_o), .cpu_clk_en_o(cpu_clk_en_o),
  .dma_clk_en_o(dma_clk_en_o), .refresh_en_o(refresh_en_o), .wake_o(wake_o)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
  localparam int AW = 20;
  logic clk = 0, rst_ni = 0;
  logic halt_op, slp_op, iostop, ccr3, ccr6, nmi, oirq, oen, bg, cst, cm1;
  logic [AW-1:0] addr;
  logic [2:0] ireq, ien;
  logic [2:0] mode;
  logic halt_n, st_n, m1_n, force_hi, cpu_en, dma_en, ref_en, inhibit, wake;
  logic [AW-1:0] raddr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.ADDR_W(AW), .N_INT(3)) dut_i (
    .clk_i(clk), .rst_ni, .halt_op_i(halt_op), .slp_op_i(slp_op), .op_addr_i(addr),
    .iostop_i(iostop), .ccr3_i(ccr3), .ccr6_i(ccr6), .nmi_i(nmi), .int_req_i(ireq),
    .int_en_i(ien), .onchip_irq_i(oirq), .onchip_en_i(oen), .bus_grant_i(bg),
    .core_st_ni(cst), .core_m1_ni(cm1), .mode_o(mode), .halt_no(halt_n), .st_no(st_n),
    .m1_no(m1_n), .bus_force_hi_o(force_hi), .cpu_clk_en_o(cpu_en), .dma_clk_en_o(dma_en),
    .refresh_en_o(ref_en), .exec_inhibit_o(inhibit), .wake_o(wake), .resume_addr_o(raddr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enter(input bit is_halt, input logic [AW-1:0] a);
    @(negedge clk);
    addr = a;
    if (is_halt) halt_op = 1; else slp_op = 1;
    @(negedge clk);
    halt_op = 0; slp_op = 0;
  endtask

  task automatic nmi_exit(input string tag);
    nmi = 1;
    @(negedge clk);
    nmi = 0;
    chk(wake == 1, tag, wake, 1);
    @(negedge clk);
    chk(mode == 0 && wake == 0, tag, mode, 0);
  endtask

  task automatic t_reset;
    chk(mode == 0 && halt_n && cpu_en && dma_en && ref_en && !force_hi && !inhibit && !wake,
        "R1 reset", {mode, halt_n, cpu_en, force_hi, wake}, 8'h0c);
  endtask

  task automatic t_normal;
    @(negedge clk); cst = 0; cm1 = 1; #1;
    chk(st_n == 0 && m1_n == 1 && halt_n, "R2 passthru", {st_n, m1_n}, 2'b01);
    cst = 1; cm1 = 0; #1;
    chk(st_n == 1 && m1_n == 0, "R2 passthru2", {st_n, m1_n}, 2'b10);
    cm1 = 1; iostop = 1; #1;
    chk(mode == 2, "R2 iostop code", mode, 2);
    iostop = 0; #1;
    chk(mode == 0, "R2 normal code", mode, 0);
  endtask

  task automatic t_halt_masked;
    @(negedge clk); halt_op = 1; slp_op = 1; addr = 20'h00123;
    @(negedge clk); halt_op = 0; slp_op = 0;
    chk(mode == 1, "R3 halt priority", mode, 1);
    chk(!halt_n && !st_n && !m1_n && inhibit && cpu_en && dma_en && ref_en && !force_hi,
        "R4 halt pins", {halt_n, st_n, m1_n, inhibit, cpu_en}, 5'b00011);
    ireq = 3'b010; ien = 3'b000; oirq = 1; oen = 0;
    repeat (3) @(negedge clk);
    chk(mode == 1 && wake == 0, "R5 masked stays", {mode, wake}, 4'h2);
    ien = 3'b010;
    @(negedge clk);
    chk(wake == 1 && mode == 1, "R5 enabled wake", {mode, wake}, 4'h3);
    chk(raddr == 20'h00124, "R6 resume addr", raddr, 20'h00124);
    ireq = 0; ien = 0; oirq = 0;
    @(negedge clk);
    chk(mode == 0 && wake == 0, "R6 one-cycle pulse", {mode, wake}, 0);
  endtask

  task automatic t_halt_onchip;
    enter(1, 20'hFFFFF);
    oirq = 1; oen = 1;
    @(negedge clk); oirq = 0; oen = 0;
    chk(wake == 1, "R5 onchip wake", wake, 1);
    chk(raddr == 20'h00000, "R6 resume wrap", raddr, 0);
    @(negedge clk);
    chk(mode == 0, "R5 back normal", mode, 0);
  endtask

  task automatic t_sleep;
    enter(0, 20'h00400);
    chk(mode == 3, "R7 sleep entry", mode, 3);
    chk(!cpu_en && !dma_en && !ref_en && !halt_n && st_n && m1_n && inhibit && force_hi,
        "R8 sleep pins", {cpu_en, dma_en, ref_en, halt_n, force_hi}, 5'b00001);
    bg = 1; #1;
    chk(force_hi == 0, "R8 grant release", force_hi, 0);
    bg = 0;
    ireq = 3'b100; ien = 3'b000;
    @(negedge clk); ireq = 0;
    chk(wake == 1, "R9 unmasked sleep wake", wake, 1);
    chk(raddr == 20'h00401, "R6 sleep resume", raddr, 20'h00401);
    @(negedge clk);
    chk(mode == 0, "R9 back normal", mode, 0);
  endtask

  task automatic t_decode;
    logic [2:0] bits [4] = '{3'b100, 3'b010, 3'b001, 3'b011};
    logic [2:0] exp  [4] = '{3'd4, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 4; i++) begin
      {iostop, ccr3, ccr6} = bits[i];
      enter(0, 20'h0);
      chk(mode == exp[i], "R10 decode", mode, exp[i]);
      {iostop, ccr3, ccr6} = 3'b000;
      nmi_exit("R10 exit");
    end
  endtask

  task automatic t_same_cycle;
    @(negedge clk); halt_op = 1; nmi = 1;
    @(negedge clk); halt_op = 0; nmi = 0;
    chk(mode == 1 && wake == 1, "R11 same-cycle wake", {mode, wake}, 4'h3);
    @(negedge clk);
    chk(mode == 0, "R11 exit next", mode, 0);
  endtask

  task automatic t_async_reset;
    enter(0, 20'h0);
    chk(mode == 3, "R12 pre", mode, 3);
    #2 rst_ni = 0; #1;
    chk(mode == 0 && cpu_en, "R12 async reset", mode, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk(mode == 0, "R12 stays normal", mode, 0);
  endtask

  initial begin
    halt_op = 0; slp_op = 0; iostop = 0; ccr3 = 0; ccr6 = 0; nmi = 0;
    oirq = 0; oen = 0; bg = 0; cst = 1; cm1 = 1; addr = 0; ireq = 0; ien = 0;
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_halt_masked();
    t_halt_onchip();
    t_sleep();
    t_decode();
    t_same_cycle();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule